// File: doc/BRIEF.md
# Dual-Threshold FIFO Watermark Status Generator

This block sits beside a multi-channel FIFO that shares one storage array among its channels. Whenever the FIFO presents the fill level of one channel, tagged with that channel's number and a valid strobe, the block compares the level against four programmable thresholds. It returns two 2-bit status words, almost-full and almost-empty, tagged with the same channel number.

Each status word carries two independent flags. Bit 0 comes from a primary threshold and bit 1 from a secondary threshold. Neither flag has hysteresis. A downstream scheduler can use the two levels as an early warning and a hard limit.

A small read/write register bus programs the four thresholds. Each threshold register keeps only as many bits as the fill level has.

Top module: `fifo_watermark_stat`

## Requirements
- R1: After reset, both status valid outputs are low, the read data bus is 0, and all four threshold registers read back as 0.
- R2: The threshold registers are selected by the byte address bits [3:2]. Offset 0 holds the primary almost-full threshold, offset 4 the primary almost-empty threshold, offset 8 the secondary almost-full threshold and offset 12 the secondary almost-empty threshold. A value written to an offset reads back from the same offset.
- R3: Only the low LVL_W bits of a written word are stored. The upper bits are ignored, and they read back as zero. With LVL_W=8, writing 0xFFFFFFFF reads back 0x000000FF.
- R4: af_flags[0] is 1 exactly when the fill level is greater than or equal to the primary almost-full threshold.
- R5: af_flags[1] is 1 exactly when the fill level is greater than or equal to the secondary almost-full threshold.
- R6: ae_flags[0] is 1 exactly when the fill level is less than or equal to the primary almost-empty threshold.
- R7: ae_flags[1] is 1 exactly when the fill level is less than or equal to the secondary almost-empty threshold.
- R8: af_valid and ae_valid are high in the cycle after the cycle in which lvl_valid is high, and low in the cycle after the cycle in which lvl_valid is low. af_chan and ae_chan carry the lvl_chan of that input.
- R9: A register write affects comparisons only from the next clock onward. A fill level presented in the same cycle as the write is compared against the old threshold.
- R10: csr_rdata shows the selected register one clock after csr_rd is high, and it holds that value until the next read.
- R11: With every threshold at its reset value of 0, a level of 0 sets all four flags. Any nonzero level sets both almost-full flags and clears both almost-empty flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lvl_valid | input | 1 | Fill-level sample strobe |
| lvl_chan | input | CH_W | Channel number of the sample |
| lvl_value | input | LVL_W | Fill level of that channel |
| csr_addr | input | 4 | Register byte address |
| csr_wr | input | 1 | Register write strobe |
| csr_rd | input | 1 | Register read strobe |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data, one clock after read |
| af_valid | output | 1 | Almost-full status valid |
| af_chan | output | CH_W | Channel of almost-full status |
| af_flags | output | 2 | Almost-full flags: bit 0 primary, bit 1 secondary |
| ae_valid | output | 1 | Almost-empty status valid |
| ae_chan | output | CH_W | Channel of almost-empty status |
| ae_flags | output | 2 | Almost-empty flags: bit 0 primary, bit 1 secondary |

## Verification
Each status result is due one clock after its fill-level sample, and each read result is due one clock after its read strobe. The bench drives every input on a falling edge and releases it on the next falling edge. It then samples the outputs at that second falling edge, which falls half a period after the single register stage has captured the result. The bench reads the absence of a result, a low valid, one falling edge later still. It checks the same-cycle write case (R9) by presenting a level together with the write, so the result must show the threshold that was in force before the write.

// File: rtl/wm_pkg.sv
package wm_pkg;

    localparam int CSR_W = 32;

    typedef enum logic [1:0] {
        SEL_AF_PRI = 2'd0,
        SEL_AE_PRI = 2'd1,
        SEL_AF_SEC = 2'd2,
        SEL_AE_SEC = 2'd3
    } thr_sel_e;

endpackage

// File: rtl/wm_regfile.sv
module wm_regfile
    import wm_pkg::*;
#(
    parameter int LVL_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [3:0]                csr_addr,
    input  logic                      csr_wr,
    input  logic                      csr_rd,
    input  logic [CSR_W-1:0]          csr_wdata,
    output logic [CSR_W-1:0]          csr_rdata,
    output logic [1:0][LVL_W-1:0]     af_thr,
    output logic [1:0][LVL_W-1:0]     ae_thr
);

    typedef struct packed {
        logic [1:0][LVL_W-1:0] af;
        logic [1:0][LVL_W-1:0] ae;
        logic [CSR_W-1:0]      rdata;
    } rf_t;

    rf_t      st_d, st_q;
    thr_sel_e sel;
    logic     unused_bits;

    // Byte lanes below the word index and data bits above the level width are dropped
    assign unused_bits = ^{csr_addr[1:0], csr_wdata[CSR_W-1:LVL_W]};
    assign sel         = thr_sel_e'(csr_addr[3:2]);

    always_comb begin
        st_d = st_q;
        if (csr_wr) begin
            case (sel)
                SEL_AF_PRI: st_d.af[0] = csr_wdata[LVL_W-1:0];
                SEL_AE_PRI: st_d.ae[0] = csr_wdata[LVL_W-1:0];
                SEL_AF_SEC: st_d.af[1] = csr_wdata[LVL_W-1:0];
                default:    st_d.ae[1] = csr_wdata[LVL_W-1:0];
            endcase
        end
        if (csr_rd) begin
            case (sel)
                SEL_AF_PRI: st_d.rdata = CSR_W'(st_q.af[0]);
                SEL_AE_PRI: st_d.rdata = CSR_W'(st_q.ae[0]);
                SEL_AF_SEC: st_d.rdata = CSR_W'(st_q.af[1]);
                default:    st_d.rdata = CSR_W'(st_q.ae[1]);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign csr_rdata = st_q.rdata;
    assign af_thr    = st_q.af;
    assign ae_thr    = st_q.ae;

    // R10: read data is only replaced by a read
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_rd |=> $stable(csr_rdata));

    // R9: thresholds move only after a write
    a_r9_thr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_wr |=> ($stable(af_thr) && $stable(ae_thr)));

    // R2: a write to offset 0 lands in the primary almost-full threshold
    a_r2_af_pri_write: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && csr_addr[3:2] == 2'd0) |=> af_thr[0] == $past(csr_wdata[LVL_W-1:0]));

endmodule

// File: rtl/wm_compare.sv
module wm_compare #(
    parameter int LVL_W = 8
) (
    input  logic [LVL_W-1:0]      level,
    input  logic [1:0][LVL_W-1:0] af_thr,
    input  logic [1:0][LVL_W-1:0] ae_thr,
    output logic [1:0]            af_hit,
    output logic [1:0]            ae_hit
);

    for (genvar g = 0; g < 2; g++) begin : g_lvl
        assign af_hit[g] = (level >= af_thr[g]);
        assign ae_hit[g] = (level <= ae_thr[g]);
    end

endmodule

// File: rtl/wm_status_out.sv
module wm_status_out #(
    parameter int CH_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [CH_W-1:0] in_chan,
    input  logic [1:0]      af_hit,
    input  logic [1:0]      ae_hit,
    output logic            out_valid,
    output logic [CH_W-1:0] out_chan,
    output logic [1:0]      out_af,
    output logic [1:0]      out_ae
);

    typedef struct packed {
        logic            valid;
        logic [CH_W-1:0] chan;
        logic [1:0]      af;
        logic [1:0]      ae;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.chan = in_chan;
            st_d.af   = af_hit;
            st_d.ae   = ae_hit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_chan  = st_q.chan;
    assign out_af    = st_q.af;
    assign out_ae    = st_q.ae;

    // R8: one-cycle latency on the strobe
    a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r8_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R8: channel tag travels with the result
    a_r8_chan_tag: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_chan == $past(in_chan));

endmodule

// File: rtl/fifo_watermark_stat.sv
module fifo_watermark_stat
    import wm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int LVL_W  = 8,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl_valid,
    input  logic [CH_W-1:0]  lvl_chan,
    input  logic [LVL_W-1:0] lvl_value,
    input  logic [3:0]       csr_addr,
    input  logic             csr_wr,
    input  logic             csr_rd,
    input  logic [31:0]      csr_wdata,
    output logic [31:0]      csr_rdata,
    output logic             af_valid,
    output logic [CH_W-1:0]  af_chan,
    output logic [1:0]       af_flags,
    output logic             ae_valid,
    output logic [CH_W-1:0]  ae_chan,
    output logic [1:0]       ae_flags
);

    logic [1:0][LVL_W-1:0] af_thr;
    logic [1:0][LVL_W-1:0] ae_thr;
    logic [1:0]            af_hit;
    logic [1:0]            ae_hit;
    logic                  st_valid;
    logic [CH_W-1:0]       st_chan;

    wm_regfile #(.LVL_W(LVL_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_addr  (csr_addr),
        .csr_wr    (csr_wr),
        .csr_rd    (csr_rd),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata),
        .af_thr    (af_thr),
        .ae_thr    (ae_thr)
    );

    wm_compare #(.LVL_W(LVL_W)) u_cmp (
        .level  (lvl_value),
        .af_thr (af_thr),
        .ae_thr (ae_thr),
        .af_hit (af_hit),
        .ae_hit (ae_hit)
    );

    wm_status_out #(.CH_W(CH_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (lvl_valid),
        .in_chan   (lvl_chan),
        .af_hit    (af_hit),
        .ae_hit    (ae_hit),
        .out_valid (st_valid),
        .out_chan  (st_chan),
        .out_af    (af_flags),
        .out_ae    (ae_flags)
    );

    assign af_valid = st_valid;
    assign ae_valid = st_valid;
    assign af_chan  = st_chan;
    assign ae_chan  = st_chan;

    // R4: primary almost-full flag against the threshold in force at sample time
    a_r4_af_pri: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_valid |=> af_flags[0] == ($past(lvl_value) >= $past(af_thr[0])));

    // R5: secondary almost-full flag
    a_r5_af_sec: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_valid |=> af_flags[1] == ($past(lvl_value) >= $past(af_thr[1])));

    // R6: primary almost-empty flag
    a_r6_ae_pri: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_valid |=> ae_flags[0] == ($past(lvl_value) <= $past(ae_thr[0])));

    // R7: secondary almost-empty flag
    a_r7_ae_sec: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_valid |=> ae_flags[1] == ($past(lvl_value) <= $past(ae_thr[1])));

endmodule

// File: tb/fifo_watermark_stat_tb_top.sv
module fifo_watermark_stat_tb_top;

    localparam int NUM_CH = 4;
    localparam int LVL_W  = 8;
    localparam int CH_W   = 2;

    // Vector fields: {chan[13:12], level[11:4], exp_af[3:2], exp_ae[1:0]}
    // Thresholds in force: AF primary 200, AE primary 20, AF secondary 150, AE secondary 50
    localparam logic [13:0] VEC [10] = '{
        {2'd0, 8'd0,   2'b00, 2'b11},
        {2'd1, 8'd20,  2'b00, 2'b11},
        {2'd2, 8'd21,  2'b00, 2'b10},
        {2'd3, 8'd50,  2'b00, 2'b10},
        {2'd0, 8'd51,  2'b00, 2'b00},
        {2'd1, 8'd149, 2'b00, 2'b00},
        {2'd2, 8'd150, 2'b10, 2'b00},
        {2'd3, 8'd199, 2'b10, 2'b00},
        {2'd0, 8'd200, 2'b11, 2'b00},
        {2'd1, 8'd255, 2'b11, 2'b00}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             lvl_valid = 1'b0;
    logic [CH_W-1:0]  lvl_chan = '0;
    logic [LVL_W-1:0] lvl_value = '0;
    logic [3:0]       csr_addr = '0;
    logic             csr_wr = 1'b0;
    logic             csr_rd = 1'b0;
    logic [31:0]      csr_wdata = '0;
    logic [31:0]      csr_rdata;
    logic             af_valid, ae_valid;
    logic [CH_W-1:0]  af_chan, ae_chan;
    logic [1:0]       af_flags, ae_flags;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    fifo_watermark_stat #(.NUM_CH(NUM_CH), .LVL_W(LVL_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_valid (lvl_valid),
        .lvl_chan  (lvl_chan),
        .lvl_value (lvl_value),
        .csr_addr  (csr_addr),
        .csr_wr    (csr_wr),
        .csr_rd    (csr_rd),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata),
        .af_valid  (af_valid),
        .af_chan   (af_chan),
        .af_flags  (af_flags),
        .ae_valid  (ae_valid),
        .ae_chan   (ae_chan),
        .ae_flags  (ae_flags)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic csr_write(input logic [3:0] addr, input logic [31:0] data);
        @(negedge clk);
        csr_addr = addr; csr_wdata = data; csr_wr = 1'b1;
        @(negedge clk);
        csr_wr = 1'b0;
    endtask

    task automatic csr_read(input logic [3:0] addr, output logic [31:0] data);
        @(negedge clk);
        csr_addr = addr; csr_rd = 1'b1;
        @(negedge clk);
        csr_rd = 1'b0;
        data = csr_rdata;
    endtask

    // Present one sample; on return the registered result is visible
    task automatic send_level(input logic [CH_W-1:0] ch, input logic [LVL_W-1:0] lvl);
        @(negedge clk);
        lvl_valid = 1'b1; lvl_chan = ch; lvl_value = lvl;
        @(negedge clk);
        lvl_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1", "af_valid", 32'(af_valid), 32'd0);
        chk("R1", "ae_valid", 32'(ae_valid), 32'd0);
        chk("R1", "rdata", csr_rdata, 32'd0);
        for (int i = 0; i < 4; i++) begin
            csr_read(4'(i * 4), rd);
            chk("R1", "threshold reset", rd, 32'd0);
        end

        // R11: default thresholds of 0
        send_level(2'd3, 8'd0);
        chk("R11", "af at level 0", 32'(af_flags), 32'h3);
        chk("R11", "ae at level 0", 32'(ae_flags), 32'h3);
        send_level(2'd2, 8'd77);
        chk("R11", "af at level 77", 32'(af_flags), 32'h3);
        chk("R11", "ae at level 77", 32'(ae_flags), 32'h0);

        // R3: upper bits dropped
        csr_write(4'd12, 32'hFFFF_FFFF);
        csr_read(4'd12, rd);
        chk("R3", "masked readback", rd, 32'h0000_00FF);
        csr_write(4'd12, 32'hABCD_1232);
        csr_read(4'd12, rd);
        chk("R3", "masked readback", rd, 32'h0000_0032);

        // R2: register map
        csr_write(4'd0, 32'd200);
        csr_write(4'd4, 32'd20);
        csr_write(4'd8, 32'd150);
        csr_read(4'd0, rd);  chk("R2", "offset 0", rd, 32'd200);
        csr_read(4'd4, rd);  chk("R2", "offset 4", rd, 32'd20);
        csr_read(4'd8, rd);  chk("R2", "offset 8", rd, 32'd150);
        csr_read(4'd12, rd); chk("R2", "offset 12", rd, 32'd50);

        // R10: read data held with no further read
        repeat (3) @(negedge clk);
        chk("R10", "rdata hold", csr_rdata, 32'd50);

        // R4..R8: vector table
        for (int i = 0; i < 10; i++) begin
            logic [13:0] v;
            v = VEC[i];
            send_level(v[13:12], v[11:4]);
            chk("R8", "valid", 32'({af_valid, ae_valid}), 32'h3);
            chk("R8", "af_chan", 32'(af_chan), 32'(v[13:12]));
            chk("R8", "ae_chan", 32'(ae_chan), 32'(v[13:12]));
            chk("R4", "af_flags[0]", 32'(af_flags[0]), 32'(v[2]));
            chk("R5", "af_flags[1]", 32'(af_flags[1]), 32'(v[3]));
            chk("R6", "ae_flags[0]", 32'(ae_flags[0]), 32'(v[0]));
            chk("R7", "ae_flags[1]", 32'(ae_flags[1]), 32'(v[1]));
            @(negedge clk);
            chk("R8", "valid drops", 32'({af_valid, ae_valid}), 32'h0);
        end

        // R9: a write shares its cycle with a sample; old threshold 200 applies
        @(negedge clk);
        csr_addr = 4'd0; csr_wdata = 32'd100; csr_wr = 1'b1;
        lvl_valid = 1'b1; lvl_chan = 2'd1; lvl_value = 8'd120;
        @(negedge clk);
        csr_wr = 1'b0; lvl_valid = 1'b0;
        chk("R9", "old threshold in same cycle", 32'(af_flags[0]), 32'd0);
        send_level(2'd1, 8'd120);
        chk("R9", "new threshold next cycle", 32'(af_flags[0]), 32'd1);

        finish_run();
    end

endmodule